// File: doc/BRIEF.md
# Polled Keyboard and Character Display Port

This block is a device controller on a simple processor load/store bus. It presents one keyboard input channel and one character display output channel as four 32-bit word registers in a fixed window at the top of the address space. Software reads these registers in a polling loop. It does not use interrupts.

On the keyboard side, a character arriving on a valid-qualified input is captured and a ready flag rises. Software spins on the keyboard status word until that flag reads 1, then reads the data word, which consumes the character. A character that lands before the previous one was consumed replaces it and marks a sticky overrun. On the display side, a ready flag reports that the display can take a character. Software writes the data word, and the block offers the low byte to the display with a valid/accept handshake. The flag returns once the display accepts the byte.

Bus reads return data combinationally in the cycle of the access. Flag and character updates take effect at the next rising clock edge.

Top module: `char_io_port`

## Requirements
- R1: The block responds (busHit = 1) only to an access whose address bits [31:16] equal 0xFFFF and whose bits [15:4] are zero. Bits [3:2] select the word, and bits [1:0] are ignored. For any other address busHit is 0 and busRdata is 0.
- R2: The keyboard status word is at offset 0x0. Bit 0 is the key-ready flag, bit 1 is the overrun flag, and all other bits read 0. After reset both flags are 0.
- R3: A cycle with keyValid = 1 captures keyChar and sets the key-ready flag from the next cycle.
- R4: A read of offset 0x4 returns the captured character zero-extended to 32 bits, and clears the key-ready flag from the next cycle. If keyValid is high in the same cycle, the read still returns the old character and the flag stays set.
- R5: If keyValid arrives while key-ready is 1 and no data read happens in that cycle, the new character replaces the old one and the overrun flag is set.
- R6: A read of offset 0x0 returns the current flags and clears the overrun flag from the next cycle, unless a new overrun occurs in that same cycle.
- R7: The display status word is at offset 0x8. Bit 0 is the display-ready flag and all other bits read 0. After reset the flag is 1 and dispValid is 0.
- R8: A write to offset 0xC while display-ready is 1 puts busWdata[7:0] on dispChar and raises dispValid from the next cycle. Display-ready reads 0 from that cycle.
- R9: dispValid and dispChar hold until a cycle with dispAccept = 1. From the next cycle dispValid is 0 and display-ready reads 1.
- R10: A write to offset 0xC while display-ready is 0 has no effect. Writes to offsets 0x0, 0x4 and 0x8 have no effect.
- R11: A read of offset 0xC returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 32 | Byte address of the access |
| busRead | input | 1 | Load strobe |
| busWrite | input | 1 | Store strobe |
| busWdata | input | 32 | Store data |
| busRdata | output | 32 | Load data, zero when not selected |
| busHit | output | 1 | Access decoded by this block |
| keyValid | input | 1 | A new character is present on keyChar |
| keyChar | input | 8 | Incoming keyboard character |
| dispValid | output | 1 | A character is offered to the display |
| dispChar | output | 8 | Character offered to the display |
| dispAccept | input | 1 | Display takes the offered character |

## Verification
The keyboard path is exercised in three ways: a single key followed by a poll and read, two keys with no read between them, and a key that coincides with a data read. Together these separate a correct overrun rule from one that fires on every key, or on keys that were already consumed. The display path is driven by a write, a second write while busy, a stall of several cycles and then an accept. This shows whether the latched byte is guarded and whether the ready flag follows the handshake. Addresses outside the window, a reserved offset in the window, and stores to read-only words check that decoding and write protection do not leak.

// File: rtl/char_io_pkg.sv
package char_io_pkg;
  localparam int SLOT_W   = 2;
  localparam int SLOT_LSB = 2;
  localparam logic [SLOT_W-1:0] SLOT_KCTL = 2'd0;
  localparam logic [SLOT_W-1:0] SLOT_KDAT = 2'd1;
  localparam logic [SLOT_W-1:0] SLOT_DCTL = 2'd2;
  localparam logic [SLOT_W-1:0] SLOT_DDAT = 2'd3;

  typedef struct packed {
    logic              hit;
    logic              rdEn;
    logic [SLOT_W-1:0] slot;
    logic              kbdCtlRd;
    logic              kbdDatRd;
    logic              dspDatWr;
  } strobe_t;
endpackage

// File: rtl/char_io_dec.sv
module char_io_dec
  import char_io_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int HI_W   = 16,
  parameter logic [HI_W-1:0] BASE_HI = 16'hFFFF
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRead,
  input  logic              busWrite,
  output strobe_t           stb
);
  localparam int MID_LSB = SLOT_LSB + SLOT_W;
  localparam int MID_MSB = ADDR_W - HI_W - 1;

  logic              inWindow;
  logic [SLOT_W-1:0] slot;

  assign slot     = busAddr[SLOT_LSB +: SLOT_W];
  assign inWindow = (busAddr[ADDR_W-1 -: HI_W] == BASE_HI) &&
                    (busAddr[MID_MSB:MID_LSB] == '0);

  always_comb begin
    stb          = '0;
    stb.hit      = inWindow;
    stb.rdEn     = inWindow && busRead;
    stb.slot     = slot;
    stb.kbdCtlRd = inWindow && busRead  && (slot == SLOT_KCTL);
    stb.kbdDatRd = inWindow && busRead  && (slot == SLOT_KDAT);
    stb.dspDatWr = inWindow && busWrite && (slot == SLOT_DDAT);
  end
endmodule

// File: rtl/char_io_dp.sv
module char_io_dp
  import char_io_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [CHAR_W-1:0] wrChar,
  input  logic              keyValid,
  input  logic [CHAR_W-1:0] keyChar,
  input  logic              dispAccept,
  output logic [DATA_W-1:0] busRdata,
  output logic              dispValid,
  output logic [CHAR_W-1:0] dispChar,
  output logic              kbdReady,
  output logic              kbdOverrun,
  output logic              dspReady
);
  localparam int PAD_W = DATA_W - CHAR_W;

  logic [CHAR_W-1:0] kbdChar;
  logic              dspTake;

  assign dspTake = stb.dspDatWr && dspReady;

  // keyboard side
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kbdChar    <= '0;
      kbdReady   <= 1'b0;
      kbdOverrun <= 1'b0;
    end else begin
      if (keyValid) begin
        kbdChar  <= keyChar;
        kbdReady <= 1'b1;
      end else if (stb.kbdDatRd) begin
        kbdReady <= 1'b0;
      end
      if (keyValid && kbdReady && !stb.kbdDatRd)
        kbdOverrun <= 1'b1;
      else if (stb.kbdCtlRd)
        kbdOverrun <= 1'b0;
    end
  end

  // display side
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dspReady <= 1'b1;
      dispChar <= '0;
    end else if (dspTake) begin
      dspReady <= 1'b0;
      dispChar <= wrChar;
    end else if (!dspReady && dispAccept) begin
      dspReady <= 1'b1;
    end
  end

  assign dispValid = !dspReady;

  // read mux
  always_comb begin
    busRdata = '0;
    if (stb.rdEn && stb.hit) begin
      unique case (stb.slot)
        SLOT_KCTL: busRdata = {{(DATA_W-2){1'b0}}, kbdOverrun, kbdReady};
        SLOT_KDAT: busRdata = {{PAD_W{1'b0}}, kbdChar};
        SLOT_DCTL: busRdata = {{(DATA_W-1){1'b0}}, dspReady};
        default:   busRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/char_io_port.sv
module char_io_port
  import char_io_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CHAR_W = 8,
  parameter int HI_W   = 16,
  parameter logic [HI_W-1:0] BASE_HI = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRead,
  input  logic              busWrite,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busHit,
  input  logic              keyValid,
  input  logic [CHAR_W-1:0] keyChar,
  output logic              dispValid,
  output logic [CHAR_W-1:0] dispChar,
  input  logic              dispAccept
);
  strobe_t stb;
  logic    kbdReady;
  logic    kbdOverrun;
  logic    dspReady;

  char_io_dec #(.ADDR_W(ADDR_W), .HI_W(HI_W), .BASE_HI(BASE_HI)) u_dec (
    .busAddr (busAddr),
    .busRead (busRead),
    .busWrite(busWrite),
    .stb     (stb)
  );

  char_io_dp #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrChar    (busWdata[CHAR_W-1:0]),
    .keyValid  (keyValid),
    .keyChar   (keyChar),
    .dispAccept(dispAccept),
    .busRdata  (busRdata),
    .dispValid (dispValid),
    .dispChar  (dispChar),
    .kbdReady  (kbdReady),
    .kbdOverrun(kbdOverrun),
    .dspReady  (dspReady)
  );

  assign busHit = stb.hit && (busRead || busWrite);
endmodule

// File: rtl/char_io_port_chk.sv
module char_io_port_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRead,
  input logic              busWrite,
  input logic [DATA_W-1:0] busRdata,
  input logic              busHit,
  input logic              keyValid,
  input logic              dispValid,
  input logic [CHAR_W-1:0] dispChar,
  input logic              dispAccept,
  input logic              kbdReady,
  input logic              kbdOverrun,
  input logic              dspReady
);
  logic kDatRd;
  logic dDatWr;
  assign kDatRd = busRead  && (busAddr == 32'hFFFF_0004);
  assign dDatWr = busWrite && (busAddr == 32'hFFFF_000C);

  AST_OUTSIDE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr[31:16] != 16'hFFFF) |-> (busRdata == '0 && !busHit)); // R1
  AST_KEY_SETS_READY: assert property (@(posedge clk) disable iff (!rstN)
    keyValid |=> kbdReady); // R3
  AST_DATA_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (kDatRd && !keyValid) |=> !kbdReady); // R4
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rstN)
    (keyValid && kbdReady && !kDatRd) |=> kbdOverrun); // R5
  AST_DISP_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (dDatWr && dspReady) |=> (dispValid && !dspReady)); // R8
  AST_DISP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid && !dispAccept) |=> (dispValid && $stable(dispChar))); // R9
  AST_DISP_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid && dispAccept) |=> (!dispValid && dspReady)); // R9
  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (!dspReady && !dispAccept) |=> $stable(dispChar)); // R10
endmodule

bind char_io_port char_io_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAR_W(CHAR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRead(busRead), .busWrite(busWrite),
  .busRdata(busRdata), .busHit(busHit), .keyValid(keyValid), .dispValid(dispValid),
  .dispChar(dispChar), .dispAccept(dispAccept), .kbdReady(kbdReady),
  .kbdOverrun(kbdOverrun), .dspReady(dspReady)
);

// File: tb/char_io_port_bench.sv
module char_io_port_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] busAddr = '0;
  logic        busRead = 1'b0;
  logic        busWrite = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busHit;
  logic        keyValid = 1'b0;
  logic [7:0]  keyChar = '0;
  logic        dispValid;
  logic [7:0]  dispChar;
  logic        dispAccept = 1'b0;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  char_io_port u_char_io_port (.*);

  typedef struct packed {
    logic [1:0]  kind;   // 0 read+check, 1 write, 2 key
    logic [31:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic        expHit;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 32'hFFFF_0000, 32'h0, 32'h0,  1'b1, 4'd2},  // R2 reset
    '{2'd0, 32'hFFFF_0008, 32'h0, 32'h1,  1'b1, 4'd7},  // R7 reset
    '{2'd2, 32'h0,         32'h41, 32'h0, 1'b0, 4'd3},
    '{2'd0, 32'hFFFF_0000, 32'h0, 32'h1,  1'b1, 4'd3},  // R3
    '{2'd0, 32'hFFFF_0004, 32'h0, 32'h41, 1'b1, 4'd4},  // R4
    '{2'd0, 32'hFFFF_0000, 32'h0, 32'h0,  1'b1, 4'd4},  // R4 cleared
    '{2'd2, 32'h0,         32'h31, 32'h0, 1'b0, 4'd5},
    '{2'd2, 32'h0,         32'h32, 32'h0, 1'b0, 4'd5},
    '{2'd0, 32'hFFFF_0002, 32'h0, 32'h3,  1'b1, 4'd5},  // R5, low bits ignored
    '{2'd0, 32'hFFFF_0000, 32'h0, 32'h1,  1'b1, 4'd6},  // R6
    '{2'd0, 32'hFFFF_0004, 32'h0, 32'h32, 1'b1, 4'd5},  // R5 replaced
    '{2'd1, 32'hFFFF_0004, 32'h55, 32'h0, 1'b1, 4'd10},
    '{2'd1, 32'hFFFF_0000, 32'hFFFF_FFFF, 32'h0, 1'b1, 4'd10},
    '{2'd0, 32'hFFFF_0000, 32'h0, 32'h0,  1'b1, 4'd10}, // R10
    '{2'd0, 32'hFFFF_0010, 32'h0, 32'h0,  1'b0, 4'd1},  // R1
    '{2'd0, 32'h7FFF_0004, 32'h0, 32'h0,  1'b0, 4'd1},  // R1
    '{2'd0, 32'hFFFF_000C, 32'h0, 32'h0,  1'b1, 4'd11}  // R11
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    busRead = 0; busWrite = 0; keyValid = 0; dispAccept = 0;
  endtask

  task automatic rd(input logic [31:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    busAddr = a; busRead = 1; busWrite = 0;
    #5;
    chk(busRdata, e, tag);
    @(posedge clk);
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWrite = 1; busRead = 0;
    @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    chk({31'b0, dispValid}, 32'd0, "R7 dispValid after reset");

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      busRead = 0; busWrite = 0; keyValid = 0;
      busAddr = TBL[i].addr;
      case (TBL[i].kind)
        2'd0: begin
          busRead = 1; #5;
          chk(busRdata, TBL[i].exp, $sformatf("R%0d row %0d rdata", TBL[i].req, i));
          chk({31'b0, busHit}, {31'b0, TBL[i].expHit}, $sformatf("R%0d row %0d hit", TBL[i].req, i));
        end
        2'd1: begin busWrite = 1; busWdata = TBL[i].data; end
        default: begin keyValid = 1; keyChar = TBL[i].data[7:0]; end
      endcase
      @(posedge clk);
    end
    idle();

    // R4: key arriving in the same cycle as a data read
    @(negedge clk);
    keyValid = 1; keyChar = 8'h61; busAddr = 32'hFFFF_0004; busRead = 1;
    #5 chk(busRdata, 32'h32, "R4 read beside new key returns old char");
    @(posedge clk);
    idle();
    rd(32'hFFFF_0000, 32'h1, "R4 ready kept, R5 no overrun");
    rd(32'hFFFF_0004, 32'h61, "R3 new char captured");
    idle();

    // display path
    wr(32'hFFFF_000C, 32'h1234_5678);
    idle();
    #5 chk({24'b0, dispChar}, 32'h78, "R8 dispChar");
    chk({31'b0, dispValid}, 32'h1, "R8 dispValid");
    rd(32'hFFFF_0008, 32'h0, "R8 ready low");
    wr(32'hFFFF_000C, 32'h99);
    wr(32'hFFFF_0008, 32'h1);
    idle();
    #5 chk({24'b0, dispChar}, 32'h78, "R10 busy write ignored");
    repeat (3) @(posedge clk);
    #5 chk({31'b0, dispValid}, 32'h1, "R9 held without accept");
    @(negedge clk) dispAccept = 1;
    @(posedge clk);
    idle();
    #5 chk({31'b0, dispValid}, 32'h0, "R9 released after accept");
    rd(32'hFFFF_0008, 32'h1, "R9 ready back");
    wr(32'hFFFF_000C, 32'hA5);
    idle();
    #5 chk({24'b0, dispChar}, 32'hA5, "R8 second char");

    // reset mid-run
    @(negedge clk) rstN = 0;
    @(negedge clk) rstN = 1;
    rd(32'hFFFF_0000, 32'h0, "R2 status after reset");
    rd(32'hFFFF_0008, 32'h1, "R7 ready after reset");
    idle();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule